// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

A purely combinational multiplier for two signed 8-bit operands that returns the exact signed 16-bit product. The multiplier operand is recoded into four radix-4 digits in the range -2..+2. Each digit picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand as one partial-product row. Halving the number of rows this way shortens the reduction stage that follows.

Each digit comes from an overlapping three-bit window of the multiplier. A small encoder turns the window into four control lines: single, double, negate and zero. A selector row turns those lines into a nine-bit ones-complement vector and a separate negate bit. A few constant bits above each row remove the need to copy the sign across the full width. The top row absorbs its own negate bit through a ten-bit half-adder chain. The remaining negate bits fill empty column slots. One rank of 4:2 compressors reduces everything to a sum vector and a carry vector, and a 16-bit carry-propagate adder joins the two.

The block has no clock and no state. The product settles after one path through the encoders, selectors, compressors and adder, and it is meant to sit between registers owned by the surrounding logic.

Top module: `booth_mul`

## Requirements
- R1: Digit *i* (0 to 3) is decoded from multiplier bits (b[2i+1], b[2i], b[2i-1]), where b[-1] = 0. The mapping is: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. The encoder raises exactly one of its zero, single and double lines, and raises negate for codes 100, 101, 110 and 111.
- R2: For every one of the 65,536 operand pairs, `prod_o` equals the signed product of `mcand_i` and `mplier_i`, read as 16-bit two's complement.
- R3: The extreme operands give exact results: -128 × -128 = 16384 (0x4000), -128 × 127 = -16256 (0xC080), 127 × -128 = -16256, and 127 × 127 = 16129.
- R4: A zero multiplicand or a zero multiplier gives `prod_o` = 0.
- R5: A group equal to 111 adds nothing to the product, even though its negate line is raised. For example, multiplier 0xFF (digits 0,0,0,-1) gives exactly -A.
- R6: Each 4:2 compressor preserves arithmetic weight: a+b+c+d+cin = sum + 2·(carry + cout). Its carry-out depends only on a, b and c, never on its own carry-in.
- R7: The top row (multiplier bits 7..5) absorbs its own negate bit through a ten-bit half-adder chain. A multiplier of 0x80 gives -128·A, and 0xC0 gives -64·A.
- R8: A negative digit in rows 0 to 2 is completed by its negate bit, which is added at column 2i. The selector's row value plus the negate bit equals digit·A. For example, multiplier 0x2A (digits -2,-1,-1,+1) gives 42·A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 8 | Signed multiplicand A |
| mplier_i | input | 8 | Signed multiplier B, recoded into radix-4 digits |
| prod_o | output | 16 | Signed product A·B |

## Verification
A wrong digit decode or a faulty selector bit in row *i* shows at `prod_o` as an error that is a multiple of 4^i·A. It appears in the same evaluation as the input change, because the block holds no state. A lost negate bit or a misplaced constant sign-extension bit gives an error of exactly 4^i or of a power of two at or above bit 8. These errors show only for multiplier patterns that create a negative digit in that row, which is why the directed patterns target each row's codes one at a time. A compressor or adder carry fault appears only for operand pairs that ripple a carry through the faulty column, so the exhaustive sweep over all operand pairs is what exposes it.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // control lines of one recoded radix-4 digit
  typedef struct packed {
    logic neg;   // negate the selected multiple
    logic one;   // select 1x multiplicand
    logic two;   // select 2x multiplicand
    logic zero;  // digit is zero, row forced to 0
  } bsel_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0] grp_i,
  output bsel_t      sel_o
);
  int dig_w;
  int ref_w;

  always_comb begin
    sel_o = '0;
    case (grp_i)
      3'b000:          sel_o.zero = 1'b1;
      3'b001, 3'b010:  sel_o.one  = 1'b1;
      3'b011:          sel_o.two  = 1'b1;
      3'b100:          begin sel_o.two = 1'b1; sel_o.neg = 1'b1; end
      3'b101, 3'b110:  begin sel_o.one = 1'b1; sel_o.neg = 1'b1; end
      default:         begin sel_o.zero = 1'b1; sel_o.neg = 1'b1; end
    endcase
    // digit the lines stand for, against the arithmetic weight of the window
    dig_w = sel_o.zero ? 0 : (sel_o.two ? 2 : 1);
    if (sel_o.neg) dig_w = -dig_w;
    ref_w = int'(grp_i[1]) + int'(grp_i[0]) - 2 * int'(grp_i[2]);
    AST_ENC_DIGIT: assert (dig_w == ref_w) else $error("encoder digit %0d, window weight %0d", dig_w, ref_w); // R1
    AST_ENC_SINGLE: assert ($onehot({sel_o.zero, sel_o.one, sel_o.two})) else $error("encoder select lines not one-hot"); // R1
  end
endmodule

// File: rtl/booth_sel.sv
module booth_sel
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  bsel_t        sel_i,
  output logic [W:0]   pp_o,   // ones-complement row, bit W is its sign
  output logic         s_o     // negate bit, added at the row LSB
);
  localparam int RW = W + 1;

  logic [RW-1:0] ext1;
  logic [RW-1:0] ext2;
  int            dig_w;
  int            row_w;

  assign ext1 = {a_i[W-1], a_i};
  assign ext2 = {a_i, 1'b0};

  always_comb begin
    pp_o = ({RW{sel_i.one}} & ext1) | ({RW{sel_i.two}} & ext2);
    pp_o = pp_o ^ {RW{sel_i.neg}};
    if (sel_i.zero) pp_o = '0;
    s_o = sel_i.neg & ~sel_i.zero;
    dig_w = sel_i.zero ? 0 : (sel_i.two ? 2 : 1);
    if (sel_i.neg) dig_w = -dig_w;
    row_w = int'($signed(pp_o)) + int'(s_o);
    AST_SEL_ROW_VALUE: assert (row_w == dig_w * int'($signed(a_i))) else $error("row value %0d, digit %0d", row_w, dig_w); // R8
    AST_SEL_ZERO_ROW: assert (!sel_i.zero || (pp_o == '0 && !s_o)) else $error("zero digit left bits in row"); // R5
  end
endmodule

// File: rtl/cmp42.sv
module cmp42 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  input  logic cin_i,
  output logic sum_o,
  output logic carry_o,
  output logic cout_o
);
  logic s1;

  always_comb begin
    s1      = a_i ^ b_i ^ c_i;
    cout_o  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    sum_o   = s1 ^ d_i ^ cin_i;
    carry_o = (s1 & d_i) | (s1 & cin_i) | (d_i & cin_i);
    AST_CMP_WEIGHT: assert ((int'(a_i) + int'(b_i) + int'(c_i) + int'(d_i) + int'(cin_i))
                            == (int'(sum_o) + 2 * (int'(carry_o) + int'(cout_o))))
      else $error("4:2 compressor lost weight"); // R6
  end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int N     = W / 2;     // radix-4 digits, one row each
  localparam int PW    = 2 * W;     // product width
  localparam int RW    = W + 1;     // selector row width
  localparam int LW    = W + 2;     // top row width with its sign-extension bits
  localparam int SLOTS = 4;         // inputs of one 4:2 compressor

  logic [RW-1:0] pp_row [N];
  logic [N-1:0]  sgn;
  logic [LW-1:0] lv;
  logic [LW-1:0] last_sum;
  logic          ha_c;
  logic [PW-1:0] slot [SLOTS];
  logic [PW-1:0] sum_v;
  logic [PW-1:0] car_v;
  logic [PW-1:0] yv;
  logic          rc;
  int            tot_w;

  // recoding and row selection
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [2:0] grp;
    bsel_t      sel;
    if (i == 0) begin : g_lsb
      assign grp = {mplier_i[1:0], 1'b0};
    end else begin : g_mid
      assign grp = mplier_i[2*i+1 : 2*i-1];
    end
    booth_enc u_enc (.grp_i(grp), .sel_o(sel));
    booth_sel #(.W(W)) u_sel (.a_i(mcand_i), .sel_i(sel), .pp_o(pp_row[i]), .s_o(sgn[i]));
  end

  // top row: constant one, inverted sign, then merge its negate bit by half adders
  assign lv = {1'b1, ~pp_row[N-1][W], pp_row[N-1][W-1:0]};

  always_comb begin
    ha_c = sgn[N-1];
    for (int k = 0; k < LW; k++) begin
      last_sum[k] = lv[k] ^ ha_c;
      ha_c        = lv[k] & ha_c;
    end
    AST_HA_LAST_ROW: assert ({ha_c, last_sum} == ({1'b0, lv} + {{LW{1'b0}}, sgn[N-1]}))
      else $error("half-adder chain sum wrong"); // R7
  end

  // column slots: row 0 with its leading bits, middle rows, top row plus spare negate bits
  always_comb begin
    for (int r = 0; r < SLOTS; r++) slot[r] = '0;
    slot[0][W-1:0] = pp_row[0][W-1:0];
    slot[0][W]     = pp_row[0][W];
    slot[0][W+1]   = pp_row[0][W];
    slot[0][W+2]   = ~pp_row[0][W];
    for (int r = 1; r < N - 1; r++) begin
      slot[r][2*r +: W]  = pp_row[r][W-1:0];
      slot[r][2*r+W]     = ~pp_row[r][W];
      slot[r][2*r+W+1]   = 1'b1;
    end
    slot[SLOTS-1][PW-1 -: LW] = last_sum;
    for (int r = 0; r < N - 1; r++) slot[SLOTS-1][2*r] = sgn[r];
  end

  // one rank of 4:2 compressors, carry-out chained to the next column
  for (genvar j = 0; j < PW; j++) begin : g_col
    logic ci;
    logic co;
    if (j == 0) begin : g_first
      assign ci = 1'b0;
    end else begin : g_next
      assign ci = g_col[j-1].co;
    end
    cmp42 u_cmp (
      .a_i(slot[0][j]), .b_i(slot[1][j]), .c_i(slot[2][j]), .d_i(slot[3][j]),
      .cin_i(ci), .sum_o(sum_v[j]), .carry_o(car_v[j]), .cout_o(co)
    );
  end

  // final carry-propagate adder
  assign yv = {car_v[PW-2:0], 1'b0};

  always_comb begin
    rc = 1'b0;
    for (int k = 0; k < PW; k++) begin
      prod_o[k] = sum_v[k] ^ yv[k] ^ rc;
      rc        = (sum_v[k] & yv[k]) | (rc & (sum_v[k] ^ yv[k]));
    end
    tot_w = int'(sum_v) + 2 * int'(car_v) + (int'(g_col[PW-1].co) << PW);
    AST_CPA_TOTAL: assert (prod_o == PW'(tot_w)) else $error("adder output differs from compressed total"); // R6
    AST_PROD_VALUE: assert (int'($signed(prod_o)) == int'($signed(mcand_i)) * int'($signed(mplier_i)))
      else $error("product %0d wrong", $signed(prod_o)); // R2
  end
endmodule

// File: tb/test_booth_mul.sv
module test_booth_mul;
  logic        clk;
  logic        rst_n;
  logic [7:0]  a;
  logic [7:0]  b;
  logic [15:0] p;
  int          n_chk;
  int          n_fail;
  bit          done;

  booth_mul #(.W(8)) i_booth_mul (.mcand_i(a), .mplier_i(b), .prod_o(p));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sx8(input logic [7:0] v);
    return (int'(v) >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, sx8(a), sx8(b), act, exp);
    end
  endtask

  // drive just after a rising edge, sample at the falling edge
  task automatic apply(input string req, input logic [7:0] av, input logic [7:0] bv);
    @(posedge clk);
    #1;
    a = av;
    b = bv;
    @(negedge clk);
    chk(req, int'($signed(p)), sx8(av) * sx8(bv));
  endtask

  task automatic t_reset;
    a = 8'h00;
    b = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R4 reset idle", int'(p), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    apply("R4 zero mult", 8'h5A, 8'h00);
    apply("R4 zero mcand", 8'h00, 8'hA5);
    apply("R4 zero mcand neg mult", 8'h00, 8'h80);
    apply("R4 both zero", 8'h00, 8'h00);
  endtask

  task automatic t_extremes;
    apply("R3 -128x-128", 8'h80, 8'h80);
    apply("R3 -128x127", 8'h80, 8'h7F);
    apply("R3 127x-128", 8'h7F, 8'h80);
    apply("R3 127x127", 8'h7F, 8'h7F);
    @(posedge clk); #1; a = 8'h80; b = 8'h80;
    @(negedge clk);
    chk("R3 raw 0x4000", int'(p), 16'h4000);
    @(posedge clk); #1; a = 8'h80; b = 8'h7F;
    @(negedge clk);
    chk("R3 raw 0xC080", int'(p), 16'hC080);
  endtask

  // each window code placed into one row, others at 000
  task automatic t_digits;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] bv;
        if (r == 0) begin
          if (c[0]) continue;
          bv = 8'(c >> 1);
        end else begin
          bv = 8'(c << (2 * r - 1));
        end
        apply("R1 window code", 8'd37, bv);
        apply("R1 window code neg", 8'hB3, bv);
      end
    end
  endtask

  task automatic t_all_ones;
    apply("R5 mult 0xFF", 8'd91, 8'hFF);
    apply("R5 mult 0xFF neg", 8'h80, 8'hFF);
    apply("R5 mult 0xFE", 8'd13, 8'hFE);
  endtask

  task automatic t_last_row;
    apply("R7 top -2", 8'd85, 8'h80);
    apply("R7 top -2 neg", 8'h80, 8'h80);
    apply("R7 top -1", 8'd1, 8'hC0);
    apply("R7 top -1 neg", 8'hFF, 8'hC0);
  endtask

  task automatic t_sign_corr;
    apply("R8 mixed neg digits", 8'd1, 8'h2A);
    apply("R8 mixed neg digits", 8'hFF, 8'h2A);
    apply("R8 mixed neg digits", 8'h7F, 8'h2A);
    apply("R8 row0 -2", 8'd3, 8'h02);
    apply("R8 row1 -1", 8'h80, 8'h0A);
  endtask

  // every operand pair; also drives every compressor carry path (R6)
  task automatic t_exhaustive;
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        apply("R2 exhaustive", 8'(ai), 8'(bi));
      end
    end
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    t_reset();
    t_zero();
    t_extremes();
    t_digits();
    t_all_ones();
    t_last_row();
    t_sign_corr();
    t_exhaustive();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule